// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector with Debounce

This block watches every pin of a GPIO port and turns pin activity into interrupt flags. Each pin has four settings. A rising-or-high enable and a falling-or-low enable select the polarity. A type bit chooses between edge triggering and level triggering. A debounce enable applies to edge types only. Together these give five usable trigger conditions per pin: high level, low level, rising edge, falling edge, and both edges.

When a condition fires, the pin's flag is set and stays set until software clears it with a write-1-to-clear pulse. The block drives an interrupt line, which is the OR of all flags. It also drives a wake-up pulse that follows exactly the same trigger conditions.

Edge detection can be filtered by a debouncer. A shared strobe samples the pins once every 2^rate cycles of the selected clock. The selected clock is either the system clock or a 10 kHz low-speed tick. The low-speed tick is delivered as a single-cycle enable pulse, already synchronized to the system clock. The pin inputs are assumed to be synchronized before they reach this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: During and directly after reset all flags, `irq_o` and `wake_o` are 0, and every pin's recorded history reads as low.
- R2: With type bit 0 (edge) and the rising enable set (`irq_en_i` bit n+16), the flag for pin n is set in the cycle after the clock edge at which the pin is first seen high after being low. This holds with debounce off.
- R3: With type bit 0 and the falling enable set (`irq_en_i` bit n), a high-to-low transition of pin n sets its flag with the same one-cycle latency.
- R4: With type bit 0 and both enables set, both rising and falling transitions set the flag.
- R5: With type bit 1 (level), the rising enable sets the flag while the pin is high, and the falling enable sets the flag while the pin is low.
- R6: A 1 in bit n of `flag_clr_i` clears flag n at the next edge and leaves every other flag unchanged. If a level condition is still present in that cycle, the set wins and the flag stays 1.
- R7: A pin with both enables at 0 never sets its flag, whatever the pin does.
- R8: `irq_o` is 1 exactly when at least one flag is 1.
- R9: `wake_o` is a registered pulse. It is high in each cycle that follows a clock edge at which any pin's trigger condition held, so it is high in the same cycle that the new flags appear.
- R10: With debounce on for an edge-type pin, the pin is sampled at each strobe. A strobe occurs every 2^`db_ctl_i[3:0]` counts of the selected clock. An edge is accepted only when two consecutive samples agree on a value that differs from the filtered level. A pulse shorter than one sample interval is ignored.
- R11: When `db_ctl_i[4]` is 1, the debounce counter advances only on `slow_tick_i` pulses. With rate 0, every tick is a sample, and a debounced edge is accepted on the second tick that sees the new value.
- R12: Level-type pins ignore debounce: a level condition sets the flag one cycle later even when debounce is on and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized pin levels |
| irq_en_i | input | 32 | Falling/low enable at bit n, rising/high enable at bit n+16 |
| lvl_type_i | input | NPINS | Per-pin trigger type: 0 edge, 1 level |
| db_en_i | input | NPINS | Per-pin debounce enable (edge types only) |
| db_ctl_i | input | 5 | Bit 4 selects the clock (0 system clock, 1 slow tick); bits [3:0] set the rate exponent |
| slow_tick_i | input | 1 | Single-cycle pulse from the 10 kHz low-speed clock |
| flag_clr_i | input | NPINS | Write-1-to-clear pulse per flag |
| flag_o | output | NPINS | Sticky per-pin interrupt flags |
| irq_o | output | 1 | OR of all flags |
| wake_o | output | 1 | Wake-up request pulse |

## Verification
A corrupted previous-value register shows up as a phantom or missing flag on the very next edge. A wrong sample or filtered-level register shows up only at the following strobe, so detection is either early or missing by up to two sample intervals. A fault in the strobe counter is visible only through the timing of debounced flags, which is why the bench brackets each debounced edge between a "not yet" check and a "by now" check. Errors in the flag registers show up at once on `irq_o` and through the isolation of each clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_kind_e;

  typedef struct packed {
    logic rise_hi;
    logic fall_lo;
  } pin_en_t;

  localparam int EN_HALF = 16;

endpackage

// File: rtl/gpio_db_strobe.sv
module gpio_db_strobe #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_slow,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             slow_tick,
  output logic             strobe
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             cnt_en;

  always_comb begin
    cnt_en = src_slow ? slow_tick : 1'b1;
    limit  = CNT_W'((64'd1 << rate_sel) - 64'd1);
    strobe = cnt_en && (cnt_q >= limit);
    cnt_d  = cnt_q;
    if (cnt_en) begin
      cnt_d = strobe ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  pin_en_t    en,
  input  trig_kind_e kind,
  input  logic       db_en,
  input  logic       strobe,
  output logic       evt
);
  logic prev_q, prev_d;
  logic smp_q, smp_d;
  logic filt_q, filt_d;
  logic agree, raw_rise, raw_fall, db_rise, db_fall, rise, fall;

  always_comb begin
    agree    = strobe && (pin == smp_q);
    raw_rise = pin & ~prev_q;
    raw_fall = ~pin & prev_q;
    db_rise  = agree & pin & ~filt_q;
    db_fall  = agree & ~pin & filt_q;
    rise     = db_en ? db_rise : raw_rise;
    fall     = db_en ? db_fall : raw_fall;
    if (kind == TRIG_LEVEL)
      evt = (en.rise_hi & pin) | (en.fall_lo & ~pin);
    else
      evt = (en.rise_hi & rise) | (en.fall_lo & fall);
    prev_d = pin;
    smp_d  = strobe ? pin : smp_q;
    filt_d = agree ? pin : filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      smp_q  <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      smp_q  <= smp_d;
      filt_q <= filt_d;
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [31:0]      irq_en_i,
  input  logic [NPINS-1:0] lvl_type_i,
  input  logic [NPINS-1:0] db_en_i,
  input  logic [SEL_W:0]   db_ctl_i,
  input  logic             slow_tick_i,
  input  logic [NPINS-1:0] flag_clr_i,
  output logic [NPINS-1:0] flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic             db_strobe;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] flag_q, flag_d;
  logic             wake_q, wake_d;

  gpio_db_strobe #(.SEL_W(SEL_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_slow (db_ctl_i[SEL_W]),
    .rate_sel (db_ctl_i[SEL_W-1:0]),
    .slow_tick(slow_tick_i),
    .strobe   (db_strobe)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    pin_en_t    en_n;
    trig_kind_e kind_n;
    assign en_n.rise_hi = irq_en_i[n + EN_HALF];
    assign en_n.fall_lo = irq_en_i[n];
    assign kind_n       = trig_kind_e'(lvl_type_i[n]);

    gpio_pin_trig u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pin_i[n]),
      .en    (en_n),
      .kind  (kind_n),
      .db_en (db_en_i[n]),
      .strobe(db_strobe),
      .evt   (evt[n])
    );
  end

  always_comb begin
    flag_d = (flag_q & ~flag_clr_i) | evt;
    wake_d = |evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      wake_q <= wake_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |flag_q;
  assign wake_o = wake_q;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] flag_o,
  input logic [NPINS-1:0] flag_clr_i,
  input logic [31:0]      irq_en_i,
  input logic [NPINS-1:0] lvl_type_i,
  input logic [NPINS-1:0] db_en_i,
  input logic             irq_o,
  input logic             wake_o,
  input logic             strobe
);
  // R7
  no_disabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o & ~$past(flag_o) & ~($past(irq_en_i[NPINS-1:0]) | $past(irq_en_i[16 +: NPINS])))) == 1'b0);

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flag_o) & ~flag_o & ~$past(flag_clr_i))) == 1'b0);

  // R9
  wake_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> irq_o);

  // R9
  irq_rise_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> wake_o);

  // R10
  db_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o & ~$past(flag_o) & $past(db_en_i & ~lvl_type_i))) |-> $past(strobe));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_o    (flag_o),
  .flag_clr_i(flag_clr_i),
  .irq_en_i  (irq_en_i),
  .lvl_type_i(lvl_type_i),
  .db_en_i   (db_en_i),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .strobe    (db_strobe)
);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [31:0]   irq_en_i = '0;
  logic [NP-1:0] lvl_type_i = '0;
  logic [NP-1:0] db_en_i = '0;
  logic [4:0]    db_ctl_i = '0;
  logic          slow_tick_i = 1'b0;
  logic [NP-1:0] flag_clr_i = '0;
  logic [NP-1:0] flag_o;
  logic          irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [NP-1:0] flags;
    bit            chk_wake;
    logic          wake;
    string         tag;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  gpio_irq_detect u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .irq_en_i(irq_en_i),
    .lvl_type_i(lvl_type_i), .db_en_i(db_en_i), .db_ctl_i(db_ctl_i),
    .slow_tick_i(slow_tick_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // monitor: pops one expectation per cycle, mid-cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (flag_o !== it.flags || irq_o !== (|it.flags) ||
          (it.chk_wake && wake_o !== it.wake)) begin
        n_fail++;
        $display("FAIL %s: flags=%h irq=%b wake=%b expected flags=%h irq=%b wake=%b",
                 it.tag, flag_o, irq_o, wake_o, it.flags, |it.flags, it.wake);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expect_out(logic [NP-1:0] f, bit cw, logic w, string tag);
    item_t it;
    it.flags = f; it.chk_wake = cw; it.wake = w; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic clear_all();
    flag_clr_i = '1;
    tick();
    flag_clr_i = '0;
    expect_out('0, 1'b0, 1'b0, "R6 clear all");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    expect_out('0, 1'b1, 1'b0, "R1 reset state");

    // R2 rising edge pin0
    irq_en_i[16] = 1'b1;
    tick();
    pin_i[0] = 1'b1;
    tick();
    expect_out(16'h0001, 1'b1, 1'b1, "R2 rising edge sets flag");
    tick();
    expect_out(16'h0001, 1'b1, 1'b0, "R9 wake single pulse, flag sticky");
    // R6 clear
    flag_clr_i[0] = 1'b1;
    tick();
    flag_clr_i[0] = 1'b0;
    expect_out(16'h0000, 1'b1, 1'b0, "R6 clear pin0");

    // R3 falling edge pin1
    irq_en_i[1] = 1'b1;
    pin_i[1] = 1'b1;
    tick();
    expect_out(16'h0000, 1'b1, 1'b0, "R3 rise ignored by falling enable");
    pin_i[1] = 1'b0;
    tick();
    expect_out(16'h0002, 1'b1, 1'b1, "R3 falling edge sets flag");
    clear_all();

    // R4 both edges pin2
    irq_en_i[2] = 1'b1; irq_en_i[18] = 1'b1;
    pin_i[2] = 1'b1;
    tick();
    expect_out(16'h0004, 1'b1, 1'b1, "R4 both-edge rise");
    clear_all();
    pin_i[2] = 1'b0;
    tick();
    expect_out(16'h0004, 1'b1, 1'b1, "R4 both-edge fall");
    clear_all();

    // R5 high level pin3
    lvl_type_i[3] = 1'b1;
    pin_i[3] = 1'b1;
    irq_en_i[19] = 1'b1;
    tick();
    expect_out(16'h0008, 1'b1, 1'b1, "R5 high level sets flag");
    flag_clr_i[3] = 1'b1;
    tick();
    expect_out(16'h0008, 1'b1, 1'b1, "R6 level re-sets on clear");
    pin_i[3] = 1'b0;
    tick();
    flag_clr_i[3] = 1'b0;
    expect_out(16'h0000, 1'b1, 1'b0, "R6 clear after level gone");
    irq_en_i[19] = 1'b0; irq_en_i[3] = 1'b1;
    tick();
    expect_out(16'h0008, 1'b1, 1'b1, "R5 low level sets flag");
    irq_en_i[3] = 1'b0;
    clear_all();

    // R7 disabled pin4
    pin_i[4] = 1'b1;
    tick();
    expect_out(16'h0000, 1'b1, 1'b0, "R7 disabled rise");
    pin_i[4] = 1'b0;
    tick();
    expect_out(16'h0000, 1'b1, 1'b0, "R7 disabled fall");

    // R6 isolation: pins 0 and 1
    pin_i[0] = 1'b0;
    tick();
    pin_i[0] = 1'b1; pin_i[1] = 1'b1;
    tick();
    pin_i[1] = 1'b0;
    tick();
    expect_out(16'h0003, 1'b1, 1'b1, "R8 two flags drive irq");
    flag_clr_i[0] = 1'b1;
    tick();
    flag_clr_i[0] = 1'b0;
    expect_out(16'h0002, 1'b1, 1'b0, "R6 clear leaves other flag");
    clear_all();

    // R10 debounce, system clock, rate 2 -> interval 4
    db_ctl_i = 5'b0_0010;
    db_en_i[5] = 1'b1;
    db_en_i[6] = 1'b1;
    irq_en_i[21] = 1'b1;
    tick(10);
    pin_i[5] = 1'b1;
    tick(3);
    expect_out(16'h0000, 1'b0, 1'b0, "R10 not yet accepted");
    tick(6);
    expect_out(16'h0020, 1'b0, 1'b0, "R10 debounced edge accepted");
    clear_all();
    pin_i[5] = 1'b0;
    tick(12);
    pin_i[5] = 1'b1;
    tick(2);
    pin_i[5] = 1'b0;
    tick(14);
    expect_out(16'h0000, 1'b1, 1'b0, "R10 short glitch ignored");

    // R11 slow tick source, rate 0
    db_ctl_i = 5'b1_0000;
    irq_en_i[22] = 1'b1;
    pin_i[6] = 1'b1;
    tick(20);
    expect_out(16'h0000, 1'b1, 1'b0, "R11 no tick no sample");
    slow_tick_i = 1'b1;
    tick();
    slow_tick_i = 1'b0;
    expect_out(16'h0000, 1'b1, 1'b0, "R11 first tick sample only");
    tick(2);
    slow_tick_i = 1'b1;
    tick();
    slow_tick_i = 1'b0;
    expect_out(16'h0040, 1'b1, 1'b1, "R11 second tick accepts edge");
    clear_all();

    // R12 level bypasses debounce
    db_en_i[7] = 1'b1;
    lvl_type_i[7] = 1'b1;
    irq_en_i[23] = 1'b1;
    pin_i[7] = 1'b1;
    tick();
    expect_out(16'h0080, 1'b1, 1'b1, "R12 level ignores debounce");

    tick(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule